// File: doc/BRIEF.md
# Multi-Level System Reset Sequencer

This block turns four reset requests of growing scope into an ordered train of one-cycle action strobes. The four levels are, from narrowest to widest: program reset, initial program reset, clear reset and power-on reset. Each level runs every action of the narrower levels first and then adds its own actions. The steps are numbered so that all steps of a level come after every step of the narrower levels. Because of this, a running sequence can be widened in place when a wider request arrives.

The program-level actions come first. They end the current operation, drop pending interruption conditions and flush prefetch buffers. Only after that does the sequence stop the CPU, reset the channels, and invalidate partly written save data. The initial level then zeroes the PSW, the CPU timer and the clock comparator, and loads the control registers. The clear level wipes the general and floating-point registers, sets up the capacity counts and clears the page descriptions. It then starts an external page-clear engine, waits for that engine's handshake, and finally invalidates the save data. Only the power-on level zeroes the time-of-day clock, and it does not finish until the clock reports the not-set state.

Top module: `rstc_top`

## Requirements
- R1: After synchronous reset, `busy`, `done` and every bit of `step_stb` are low.
- R2: `rst_req` bit 0 requests program reset, bit 1 initial program reset, bit 2 clear reset and bit 3 power-on reset. When several bits are set, the highest set bit selects the level.
- R3: Program reset pulses these strobe bits, one per cycle, in this order: 0 end operation, 1 clear pending conditions, 2 flush prefetch, 3 stop CPU, 4 channel reset, 5 invalidate partial save. Strobe k appears k+1 cycles after the edge that accepts the request.
- R4: Strobe bit 5 fires only if `save_busy` was high in the cycle the step is issued. Otherwise that cycle passes with no strobe, and the save data is left untouched.
- R5: Initial program reset runs the steps of R3 and then bits 6 (PSW), 7 (CPU timer), 8 (clock comparator) and 9 (control registers), one per cycle.
- R6: Clear reset runs the steps of R5, then bits 10 (GPRs), 11 (FPRs), 12 (capacity counts), 13 (page descriptions) and 14 (page-clear start). It then waits, with no strobe, until `pgclr_done` is sampled high. Bit 15 (save invalidate) follows one cycle after that.
- R7: Power-on reset runs the steps of R6 and then bit 16 (time-of-day clear). It finishes only in the cycle after `tod_notset` is sampled high.
- R8: `busy` is high from the cycle after a request is accepted until the cycle `done` pulses. `done` is a single-cycle pulse with `busy` low. No strobe appears while idle.
- R9: A request that arrives while a sequence runs, up to and including its final issuing cycle, is merged into it. A wider level extends the running sequence, with one `done`. An equal or narrower level changes nothing.
- R10: At most one `step_stb` bit is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_req | input | 4 | Reset level requests, one bit per level |
| save_busy | input | 1 | A save operation is in progress |
| pgclr_done | input | 1 | Page-clear engine finished |
| tod_notset | input | 1 | Time-of-day clock is in the not-set state |
| step_stb | output | 17 | One-cycle action strobes, one bit per step |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence complete pulse |

## Verification
The bench applies every one of the fifteen non-zero request patterns, each with save activity both off and on. This separates the priority pick among several request bits from the gating of the partial-save step. Each pattern also uses different handshake delays for the page-clear engine and the clock. A cycle-exact comparison of the strobe vector therefore shows whether a wait step stalls for the right number of cycles. Separate runs inject a second request mid-sequence: a wider level on the final issuing cycle, a wider level during a wait, and equal or narrower levels. These runs show whether merging extends the sequence or leaves it alone.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  localparam int NLVL  = 4;
  localparam int LVLW  = $clog2(NLVL);
  localparam int NSTEP = 17;
  localparam int IDXW  = $clog2(NSTEP);

  localparam logic [IDXW-1:0] ST_SAVE_PART = IDXW'(5);
  localparam logic [IDXW-1:0] ST_PGCLR     = IDXW'(14);
  localparam logic [IDXW-1:0] ST_TOD       = IDXW'(16);

  typedef enum logic [1:0] {SQ_IDLE, SQ_RUN, SQ_WAIT} sq_state_t;

  function automatic logic [IDXW-1:0] last_step(input logic [LVLW-1:0] lvl);
    case (lvl)
      2'd0:    return IDXW'(5);
      2'd1:    return IDXW'(9);
      2'd2:    return IDXW'(15);
      default: return IDXW'(16);
    endcase
  endfunction
endpackage

// File: rtl/rstc_req_merge.sv
module rstc_req_merge
  import rstc_pkg::*;
(
  input  logic [NLVL-1:0] req,
  input  logic            active,
  input  logic [LVLW-1:0] cur_lvl,
  output logic            any_req,
  output logic [LVLW-1:0] lvl_eff
);
  logic [LVLW-1:0] hi;

  always_comb begin
    hi = '0;
    for (int i = 0; i < NLVL; i++)
      if (req[i]) hi = LVLW'(i);
  end

  assign any_req = |req;

  always_comb begin
    if (!active)                    lvl_eff = hi;
    else if (any_req && hi > cur_lvl) lvl_eff = hi;
    else                            lvl_eff = cur_lvl;
  end
endmodule

// File: rtl/rstc_seq.sv
module rstc_seq
  import rstc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [NLVL-1:0] rst_req,
  input  logic            pgclr_done,
  input  logic            tod_notset,
  output logic            issue,
  output logic [IDXW-1:0] idx,
  output logic            fin,
  output logic            busy_nxt
);
  sq_state_t       st_q, st_d;
  logic [IDXW-1:0] idx_q, idx_d;
  logic [LVLW-1:0] lvl_q, lvl_eff;
  logic            any_req, at_last, wait_step, hs;

  rstc_req_merge u_merge (
    .req     (rst_req),
    .active  (st_q != SQ_IDLE),
    .cur_lvl (lvl_q),
    .any_req (any_req),
    .lvl_eff (lvl_eff)
  );

  assign at_last   = (idx_q == last_step(lvl_eff));
  assign wait_step = (idx_q == ST_PGCLR) || (idx_q == ST_TOD);
  assign hs        = (idx_q == ST_PGCLR) ? pgclr_done : tod_notset;

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    fin   = 1'b0;
    case (st_q)
      SQ_IDLE: if (any_req) begin
        st_d  = SQ_RUN;
        idx_d = '0;
      end
      SQ_RUN: begin
        if (wait_step)    st_d = SQ_WAIT;
        else if (at_last) begin st_d = SQ_IDLE; fin = 1'b1; end
        else              idx_d = idx_q + 1'b1;
      end
      SQ_WAIT: if (hs) begin
        if (at_last) begin st_d = SQ_IDLE; fin = 1'b1; end
        else begin st_d = SQ_RUN; idx_d = idx_q + 1'b1; end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= SQ_IDLE;
      idx_q <= '0;
      lvl_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      if (st_q != SQ_IDLE || any_req) lvl_q <= lvl_eff;
    end
  end

  assign issue    = (st_q == SQ_RUN);
  assign idx      = idx_q;
  assign busy_nxt = (st_d != SQ_IDLE);

  AST_PGCLR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (st_q == SQ_WAIT && idx_q == ST_PGCLR && !pgclr_done) |=> (st_q == SQ_WAIT && idx_q == ST_PGCLR)); // R6
  AST_TOD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (st_q == SQ_WAIT && idx_q == ST_TOD && !tod_notset) |=> (st_q == SQ_WAIT)); // R7
  AST_LVL_MONO: assert property (@(posedge clk) disable iff (rst)
    (st_q != SQ_IDLE && $past(st_q) != SQ_IDLE) |-> (lvl_q >= $past(lvl_q))); // R9
endmodule

// File: rtl/rstc_out.sv
module rstc_out
  import rstc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             issue,
  input  logic [IDXW-1:0]  idx,
  input  logic             fin,
  input  logic             busy_nxt,
  input  logic             save_busy,
  output logic [NSTEP-1:0] step_stb,
  output logic             busy,
  output logic             done
);
  logic [NSTEP-1:0] sel;

  generate
    for (genvar k = 0; k < NSTEP; k++) begin : g_sel
      if (k == int'(ST_SAVE_PART)) begin : g_gated
        assign sel[k] = issue && (idx == IDXW'(k)) && save_busy;
      end else begin : g_plain
        assign sel[k] = issue && (idx == IDXW'(k));
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      step_stb <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else begin
      step_stb <= sel;
      busy     <= busy_nxt;
      done     <= fin;
    end
  end

  AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(step_stb)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!busy && !done) |-> (step_stb == '0)); // R8
  AST_SAVE_GATE: assert property (@(posedge clk) disable iff (rst)
    step_stb[ST_SAVE_PART] |-> $past(save_busy)); // R4
endmodule

// File: rtl/rstc_top.sv
module rstc_top
  import rstc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [NLVL-1:0]  rst_req,
  input  logic             save_busy,
  input  logic             pgclr_done,
  input  logic             tod_notset,
  output logic [NSTEP-1:0] step_stb,
  output logic             busy,
  output logic             done
);
  logic            issue, fin, busy_nxt;
  logic [IDXW-1:0] idx;

  rstc_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .rst_req    (rst_req),
    .pgclr_done (pgclr_done),
    .tod_notset (tod_notset),
    .issue      (issue),
    .idx        (idx),
    .fin        (fin),
    .busy_nxt   (busy_nxt)
  );

  rstc_out u_out (
    .clk       (clk),
    .rst       (rst),
    .issue     (issue),
    .idx       (idx),
    .fin       (fin),
    .busy_nxt  (busy_nxt),
    .save_busy (save_busy),
    .step_stb  (step_stb),
    .busy      (busy),
    .done      (done)
  );
endmodule

// File: tb/tb_rstc_top.sv
`timescale 1ns/1ps
module tb_rstc_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  rst_req = '0;
  logic        save_busy = 1'b0;
  logic        pgclr_done = 1'b0;
  logic        tod_notset = 1'b0;
  logic [16:0] step_stb;
  logic        busy, done;
  int          checks = 0;
  int          errors = 0;
  bit          finished = 1'b0;

  always #2 clk = ~clk;

  rstc_top dut (
    .clk(clk), .rst(rst), .rst_req(rst_req), .save_busy(save_busy),
    .pgclr_done(pgclr_done), .tod_notset(tod_notset),
    .step_stb(step_stb), .busy(busy), .done(done)
  );

  function automatic int hi_of(input logic [3:0] r);
    int h = -1;
    for (int i = 0; i < 4; i++) if (r[i]) h = i;
    return h;
  endfunction

  function automatic int last_of(input int l);
    return (l == 0) ? 5 : (l == 1) ? 9 : (l == 2) ? 15 : 16;
  endfunction

  function automatic int pos_of(input int k, input int d);
    return (k <= 14) ? k + 1 : (k == 15) ? 17 + d : 18 + d;
  endfunction

  function automatic int done_of(input int l, input int d, input int w);
    return (l == 0) ? 6 : (l == 1) ? 10 : (l == 2) ? 17 + d : 19 + d + w;
  endfunction

  function automatic string lvl_tag(input int l);
    return (l == 0) ? "R3" : (l == 1) ? "R5" : (l == 2) ? "R6" : "R7";
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // r0 accepted first; r1 (if u >= 0) driven at offset u during the run
  task automatic run(input logic [3:0] r0, input logic [3:0] r1, input int u,
                     input bit sv, input int d, input int w, input string tag);
    int l, dt, s14, s16;
    logic [16:0] ev;
    l = hi_of(r0);
    if (u >= 0 && hi_of(r1) > l) l = hi_of(r1);
    dt  = done_of(l, d, w);
    s14 = -1;
    s16 = -1;
    @(negedge clk);
    rst_req = r0; save_busy = sv; pgclr_done = 1'b0; tod_notset = 1'b0;
    @(posedge clk);
    for (int t = 0; t <= dt + 3; t++) begin
      @(negedge clk);
      ev = '0;
      for (int k = 0; k <= last_of(l); k++)
        if (pos_of(k, d) == t && (k != 5 || sv)) ev[k] = 1'b1;
      if (step_stb !== ev) begin
        if ((step_stb ^ ev) == 17'h20) chk(1'b0, "R4", "save strobe", 32'(step_stb), 32'(ev));
        else chk(1'b0, (u >= 0) ? "R9" : lvl_tag(l), {tag, " strobes"}, 32'(step_stb), 32'(ev));
      end else chk(1'b1, lvl_tag(l), "strobes", 0, 0);
      chk($countones(step_stb) <= 1, "R10", "onehot", 32'(step_stb), 0);
      chk(busy === (t < dt), "R8", "busy", 32'(busy), 32'(t < dt));
      chk(done === (t == dt), (u >= 0) ? "R9" : "R8", "done", 32'(done), 32'(t == dt));
      if (step_stb[14]) s14 = t;
      if (step_stb[16]) s16 = t;
      rst_req    = (t == u) ? r1 : 4'b0;
      pgclr_done = (s14 >= 0 && t == s14 + d);
      tod_notset = (s16 >= 0 && t >= s16 + w);
    end
    tod_notset = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && step_stb === '0, "R1", "reset state",
        {14'b0, busy, done, step_stb}, 0);
    // R2: all request patterns, save activity off and on, varied handshake delays
    for (int v = 1; v < 16; v++)
      for (int s = 0; s < 2; s++)
        run(4'(v), 4'b0, -1, s[0], 1 + v % 3, 1 + (v + s) % 2, "R2");
    // R9: widen on final issuing cycle, widen during wait, equal and narrower ignored
    run(4'b0001, 4'b1000, 5, 1'b0, 2, 1, "R9 widen last");
    run(4'b0100, 4'b1000, 16, 1'b1, 3, 2, "R9 widen wait");
    run(4'b0010, 4'b0100, 2, 1'b0, 1, 1, "R9 widen early");
    run(4'b0100, 4'b0001, 3, 1'b1, 2, 1, "R9 narrower");
    run(4'b0010, 4'b0010, 8, 1'b0, 1, 1, "R9 equal");
    finished = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!finished && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule